// File: doc/BRIEF.md
# ADC SPI Bring-up and Readout Sequencer

This block is an SPI master that prepares a 24-bit delta-sigma converter for use and then collects its results. After its own reset ends, it releases the converter's reset pin and waits a programmed number of cycles, because the converter ignores commands during that time. It then sends the stop-continuous command, writes a block of configuration, offset and gain registers in one chip-select frame, and sends the start-continuous command. Only after that does it raise the converter's START pin.

Once START is high, every falling edge of the converter's active-low data-ready line starts a three-byte read. The bytes are packed most significant first into a 24-bit word, and that word is presented to the host with a one-cycle valid strobe. The register image comes from an input port. The SCLK divider is computed from the system clock and converter clock frequencies, so that the serial clock never exceeds the converter's limit.

Top module: `adc_seq_top`

## Requirements
- R1: While `rst_ni` is low: `cs_no` is high, `sclk_o` is low, `adc_start_o` is low, `adc_rst_no` is low, and `result_valid_o` and `overrun_o` are low.
- R2: After `rst_ni` rises, `adc_rst_no` goes high and stays high. The first falling edge of `cs_no` comes no sooner than `PWRUP_CYC` clock cycles after the release.
- R3: The SPI link runs in mode 1, most significant bit first. SCLK is low whenever `cs_no` is high. MOSI changes on SCLK rising edges, and MISO is captured on SCLK falling edges.
- R4: Every SCLK high phase and every SCLK low phase lasts at least `HALF_CYC` clock cycles. `HALF_CYC` is derived so that a full SCLK period is at least 1.8 converter clock periods (`SYS_CLK_KHZ`, `CONV_CLK_KHZ`).
- R5: The first frame is the single byte 0x11 (stop continuous read), alone in its own chip-select frame.
- R6: The second frame is a single unbroken chip-select-low frame. It holds 0x40 OR `START_ADDR`, then `NREG`-1, then the register bytes k = 0..`NREG`-1, each taken from `cfg_image_i[8k+7:8k]`.
- R7: The third frame is the single byte 0x10 (start continuous read). `adc_start_o` stays low through all three frames, rises only while `cs_no` is high after the third frame, and never falls again.
- R8: Between any two frames, `cs_no` stays high for at least `CS_GAP_SCLK` × 2 × `HALF_CYC` cycles.
- R9: Data-ready edges that arrive before `adc_start_o` is high are ignored: they start no frame and produce no result. The bring-up also completes while data-ready keeps toggling.
- R10: With `adc_start_o` high, each falling edge of `drdy_ni` starts one three-byte frame. The bytes b0, b1, b2 are returned as `result_o` = {b0,b1,b2} together with a `result_valid_o` pulse exactly one cycle long.
- R11: A falling edge of `drdy_ni` that arrives during a read frame, or during the chip-select gap after it, makes `overrun_o` pulse for one cycle. The edge is dropped and starts no extra frame, and the read already in progress still delivers its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_image_i | input | NREG*8 | Register image; byte k in bits [8k+7:8k] |
| sclk_o | output | 1 | SPI clock, idles low |
| mosi_o | output | 1 | SPI data to converter |
| miso_i | input | 1 | SPI data from converter |
| cs_no | output | 1 | Active-low chip select |
| adc_rst_no | output | 1 | Converter reset pin, active low |
| adc_start_o | output | 1 | Converter START pin |
| drdy_ni | input | 1 | Converter data-ready, active low, asynchronous |
| result_valid_o | output | 1 | One-cycle strobe for a new result |
| result_o | output | 24 | Last assembled conversion word |
| overrun_o | output | 1 | One-cycle strobe for a dropped data-ready edge |

## Verification
The assertions check the pin-level rules on every cycle:
- SCLK stays quiet while chip select is high.
- The minimum SCLK half-period and the minimum chip-select gap are met.
- START and the reset pin are monotonic, and START rises only with chip select high.
- The valid strobe lasts one cycle, and overrun occurs only once streaming has started.

Only the bench scenarios can show the content of the SPI traffic. These cover the command bytes and their framing, the unbroken register burst, the power-up delay, the data-ready edges ignored during bring-up, the assembled result words and the overrun drop. A slave model in the bench decodes this traffic at the pins.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {ST_PWRUP, ST_XFER, ST_GAP, ST_STREAM} seq_state_e;
  typedef enum logic [1:0] {XF_STOP, XF_WREG, XF_RUN, XF_READ} xfer_e;

  localparam logic [7:0] CMD_STOP_CONT  = 8'h11;
  localparam logic [7:0] CMD_START_CONT = 8'h10;
  localparam logic [7:0] CMD_WRITE_REG  = 8'h40;
  localparam logic [7:0] READ_FILL      = 8'h00;
endpackage

// File: rtl/adc_spi_byte.sv
module adc_spi_byte #(
  parameter int unsigned HALF_CYC = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);
  localparam int unsigned HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic          busy_q;
  logic [HW-1:0] half_q;
  logic [2:0]    bit_q;
  logic [7:0]    tx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      half_q <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      sclk_o <= 1'b0;
      mosi_o <= 1'b0;
      done_o <= 1'b0;
      rx_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (go_i) begin
          busy_q <= 1'b1;
          tx_q   <= tx_i;
          half_q <= '0;
          bit_q  <= '0;
        end
      end else if (half_q == HW'(HALF_CYC - 1)) begin
        half_q <= '0;
        if (!sclk_o) begin
          // mode 1: launch on rising edge
          sclk_o <= 1'b1;
          mosi_o <= tx_q[7];
          tx_q   <= {tx_q[6:0], 1'b0};
        end else begin
          // capture on falling edge
          sclk_o <= 1'b0;
          rx_o   <= {rx_o[6:0], miso_i};
          bit_q  <= bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            busy_q <= 1'b0;
            done_o <= 1'b1;
          end
        end
      end else begin
        half_q <= half_q + HW'(1);
      end
    end
  end
endmodule

// File: rtl/adc_drdy_edge.sv
module adc_drdy_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic drdy_ni,
  output logic fall_o
);
  logic [2:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 3'b111;
    else         sync_q <= {sync_q[1:0], drdy_ni};
  end

  assign fall_o = sync_q[2] & ~sync_q[1];
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned NREG       = 9,
  parameter int unsigned START_ADDR = 0,
  parameter int unsigned PWRUP_CYC  = 4096,
  parameter int unsigned GAP_CYC    = 56
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREG*8-1:0] cfg_image_i,
  input  logic            eng_done_i,
  input  logic [7:0]      eng_rx_i,
  input  logic            drdy_fall_i,
  output logic            go_o,
  output logic [7:0]      tx_o,
  output logic            cs_no,
  output logic            adc_rst_no,
  output logic            start_o,
  output logic            valid_o,
  output logic [23:0]     result_o,
  output logic            overrun_o
);
  localparam int unsigned IDX_W   = $clog2(NREG + 3);
  localparam int unsigned CNT_MAX = (PWRUP_CYC > GAP_CYC) ? PWRUP_CYC : GAP_CYC;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  seq_state_e       state_q;
  xfer_e            kind_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] last_idx;
  logic [CNT_W-1:0] cnt_q;
  logic [15:0]      acc_q;
  logic [7:0]       wr_byte;

  always_comb begin
    case (kind_q)
      XF_WREG: last_idx = IDX_W'(NREG + 1);
      XF_READ: last_idx = IDX_W'(2);
      default: last_idx = '0;
    endcase
  end

  always_comb begin
    wr_byte = '0;
    if (idx_q == '0)          wr_byte = CMD_WRITE_REG | 8'(START_ADDR);
    else if (idx_q == IDX_W'(1)) wr_byte = 8'(NREG - 1);
    for (int k = 0; k < NREG; k++)
      if (idx_q == IDX_W'(k + 2)) wr_byte = cfg_image_i[8*k +: 8];
  end

  always_comb begin
    case (kind_q)
      XF_STOP: tx_o = CMD_STOP_CONT;
      XF_RUN:  tx_o = CMD_START_CONT;
      XF_READ: tx_o = READ_FILL;
      default: tx_o = wr_byte;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_PWRUP;
      kind_q     <= XF_STOP;
      idx_q      <= '0;
      cnt_q      <= '0;
      acc_q      <= '0;
      go_o       <= 1'b0;
      cs_no      <= 1'b1;
      adc_rst_no <= 1'b0;
      start_o    <= 1'b0;
      valid_o    <= 1'b0;
      result_o   <= '0;
      overrun_o  <= 1'b0;
    end else begin
      go_o       <= 1'b0;
      valid_o    <= 1'b0;
      overrun_o  <= drdy_fall_i && start_o && (state_q != ST_STREAM);
      adc_rst_no <= 1'b1;
      case (state_q)
        ST_PWRUP: begin
          if (cnt_q == CNT_W'(PWRUP_CYC - 1)) begin
            cnt_q   <= '0;
            kind_q  <= XF_STOP;
            idx_q   <= '0;
            cs_no   <= 1'b0;
            go_o    <= 1'b1;
            state_q <= ST_XFER;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_XFER: begin
          if (eng_done_i) begin
            if (kind_q == XF_READ) acc_q <= {acc_q[7:0], eng_rx_i};
            if (idx_q == last_idx) begin
              cs_no   <= 1'b1;
              cnt_q   <= '0;
              state_q <= ST_GAP;
              if (kind_q == XF_READ) begin
                valid_o  <= 1'b1;
                result_o <= {acc_q, eng_rx_i};
              end
            end else begin
              idx_q <= idx_q + IDX_W'(1);
              go_o  <= 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (cnt_q == CNT_W'(GAP_CYC - 1)) begin
            cnt_q <= '0;
            idx_q <= '0;
            case (kind_q)
              XF_STOP: begin
                kind_q <= XF_WREG; cs_no <= 1'b0; go_o <= 1'b1; state_q <= ST_XFER;
              end
              XF_WREG: begin
                kind_q <= XF_RUN; cs_no <= 1'b0; go_o <= 1'b1; state_q <= ST_XFER;
              end
              XF_RUN: begin
                start_o <= 1'b1;
                state_q <= ST_STREAM;
              end
              default: state_q <= ST_STREAM;
            endcase
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: begin
          if (drdy_fall_i) begin
            kind_q  <= XF_READ;
            idx_q   <= '0;
            cs_no   <= 1'b0;
            go_o    <= 1'b1;
            state_q <= ST_XFER;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top #(
  parameter int unsigned SYS_CLK_KHZ  = 50000,
  parameter int unsigned CONV_CLK_KHZ = 7373,
  parameter int unsigned NREG         = 9,
  parameter int unsigned START_ADDR   = 0,
  parameter int unsigned PWRUP_CYC    = 4096,
  parameter int unsigned CS_GAP_SCLK  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NREG*8-1:0] cfg_image_i,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no,
  output logic              adc_rst_no,
  output logic              adc_start_o,
  input  logic              drdy_ni,
  output logic              result_valid_o,
  output logic [23:0]       result_o,
  output logic              overrun_o
);
  // SCLK period >= 1.8 converter clocks, rounded up to whole system cycles
  localparam int unsigned PER_CYC  = (18 * SYS_CLK_KHZ + 10 * CONV_CLK_KHZ - 1) / (10 * CONV_CLK_KHZ);
  localparam int unsigned HALF_RAW = (PER_CYC + 1) / 2;
  localparam int unsigned HALF_CYC = (HALF_RAW < 1) ? 1 : HALF_RAW;
  localparam int unsigned GAP_CYC  = CS_GAP_SCLK * 2 * HALF_CYC;

  logic       eng_go;
  logic [7:0] eng_tx;
  logic       eng_done;
  logic [7:0] eng_rx;
  logic       drdy_fall;

  adc_drdy_edge u_drdy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .drdy_ni (drdy_ni),
    .fall_o  (drdy_fall)
  );

  adc_spi_byte #(.HALF_CYC(HALF_CYC)) u_spi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (eng_go),
    .tx_i   (eng_tx),
    .miso_i (miso_i),
    .sclk_o (sclk_o),
    .mosi_o (mosi_o),
    .done_o (eng_done),
    .rx_o   (eng_rx)
  );

  adc_seq_ctrl #(
    .NREG       (NREG),
    .START_ADDR (START_ADDR),
    .PWRUP_CYC  (PWRUP_CYC),
    .GAP_CYC    (GAP_CYC)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_image_i (cfg_image_i),
    .eng_done_i  (eng_done),
    .eng_rx_i    (eng_rx),
    .drdy_fall_i (drdy_fall),
    .go_o        (eng_go),
    .tx_o        (eng_tx),
    .cs_no       (cs_no),
    .adc_rst_no  (adc_rst_no),
    .start_o     (adc_start_o),
    .valid_o     (result_valid_o),
    .result_o    (result_o),
    .overrun_o   (overrun_o)
  );
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int unsigned HALF_CYC = 7,
  parameter int unsigned GAP_CYC  = 56
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sclk_o,
  input logic cs_no,
  input logic adc_rst_no,
  input logic adc_start_o,
  input logic result_valid_o,
  input logic overrun_o
);
  localparam int unsigned SAT = (HALF_CYC > GAP_CYC) ? HALF_CYC : GAP_CYC;
  localparam int unsigned CW  = $clog2(SAT + 2);

  logic          sclk_d, cs_d;
  logic [CW-1:0] sclk_run, cs_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d   <= 1'b0;
      cs_d     <= 1'b1;
      sclk_run <= CW'(SAT);
      cs_run   <= CW'(SAT);
    end else begin
      sclk_d <= sclk_o;
      cs_d   <= cs_no;
      if (sclk_o != sclk_d) sclk_run <= CW'(1);
      else if (sclk_run != CW'(SAT)) sclk_run <= sclk_run + CW'(1);
      if (cs_no != cs_d) cs_run <= CW'(1);
      else if (cs_run != CW'(SAT)) cs_run <= cs_run + CW'(1);
    end
  end

  a_r3_sclk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  a_r4_sclk_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o != sclk_d) |-> (sclk_run >= CW'(HALF_CYC)));

  a_r8_cs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && cs_d) |-> (cs_run >= CW'(GAP_CYC)));

  a_r7_start_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |=> adc_start_o);

  a_r7_start_cs_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(adc_start_o) |-> cs_no);

  a_r2_rst_pin_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_rst_no |=> adc_rst_no);

  a_r10_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);

  a_r11_overrun_started: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> adc_start_o);
endmodule

bind adc_seq_top adc_seq_chk #(.HALF_CYC(HALF_CYC), .GAP_CYC(GAP_CYC)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sclk_o         (sclk_o),
  .cs_no          (cs_no),
  .adc_rst_no     (adc_rst_no),
  .adc_start_o    (adc_start_o),
  .result_valid_o (result_valid_o),
  .overrun_o      (overrun_o)
);

// File: tb/tb_adc_seq_top.sv
module tb_adc_seq_top;
  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 9;
  localparam int PWRUP      = 600;
  localparam int SYS_KHZ    = 50000;
  localparam int CONV_KHZ   = 7373;
  localparam int GAP_SCLK   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NREG*8-1:0] cfg;
  logic sclk, mosi, miso = 1'b0, cs_n, arst_n, start, drdy_n = 1'b1;
  logic valid, overrun;
  logic [23:0] result;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_seq_top #(
    .SYS_CLK_KHZ(SYS_KHZ), .CONV_CLK_KHZ(CONV_KHZ), .NREG(NREG),
    .START_ADDR(0), .PWRUP_CYC(PWRUP), .CS_GAP_SCLK(GAP_SCLK)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_image_i(cfg), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .cs_no(cs_n), .adc_rst_no(arst_n), .adc_start_o(start),
    .drdy_ni(drdy_n), .result_valid_o(valid), .result_o(result), .overrun_o(overrun)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, rel_cyc = 0;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // slave model, mode 1
  logic [7:0]  fb [16][16];
  int          flen [16];
  logic        fstart [16];
  int          nfr = 0, cur_len = 0, bitc = 0;
  bit          in_frame = 0;
  logic [7:0]  mosi_sh = '0;
  logic [23:0] adc_word = '0, miso_sh = '0;
  int          first_cs = -1, last_cs_rise = -1, min_gap = 1 << 30;
  int          last_rise = -1, min_per = 1 << 30;
  int          n_valid = 0, n_over = 0;

  always @(negedge cs_n) if (rst_n) begin
    in_frame = 1; cur_len = 0; bitc = 0; last_rise = -1;
    miso_sh = adc_word;
    if (nfr < 16) fstart[nfr] = start;
    if (first_cs < 0) first_cs = cyc - rel_cyc;
    if (last_cs_rise >= 0 && cyc - last_cs_rise < min_gap) min_gap = cyc - last_cs_rise;
  end
  always @(posedge cs_n) if (in_frame) begin
    in_frame = 0;
    if (nfr < 16) flen[nfr] = cur_len;
    nfr++;
    last_cs_rise = cyc;
  end
  always @(posedge sclk) if (!cs_n) begin
    miso = miso_sh[23];
    miso_sh = {miso_sh[22:0], 1'b0};
    if (last_rise >= 0 && cyc - last_rise < min_per) min_per = cyc - last_rise;
    last_rise = cyc;
  end
  always @(negedge sclk) if (!cs_n) begin
    mosi_sh = {mosi_sh[6:0], mosi};
    bitc++;
    if (bitc == 8) begin
      if (nfr < 16 && cur_len < 16) fb[nfr][cur_len] = mosi_sh;
      cur_len++;
      bitc = 0;
    end
  end
  always @(negedge clk) begin
    if (rst_n && valid) n_valid++;
    if (rst_n && overrun) n_over++;
  end

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check(cs_n == 1'b1, "R1 cs high", cs_n, 1);
    check(sclk == 1'b0, "R1 sclk low", sclk, 0);
    check(start == 1'b0, "R1 start low", start, 0);
    check(arst_n == 1'b0, "R1 adc reset low", arst_n, 0);
    check(valid == 1'b0 && overrun == 1'b0, "R1 strobes low", {valid, overrun}, 0);
    rst_n = 1'b1;
    rel_cyc = cyc;
    repeat (3) @(negedge clk);
    check(arst_n == 1'b1, "R2 adc reset released", arst_n, 1);
  endtask

  task automatic t_bringup();
    int guard = 0;
    // drdy keeps toggling during bring-up (R9)
    while (!start && guard < 20000) begin
      drdy_n = ~drdy_n;
      repeat (50) @(negedge clk);
      guard += 50;
    end
    drdy_n = 1'b1;
    check(start == 1'b1, "R9 bring-up completes with drdy toggling", start, 1);
    check(first_cs >= PWRUP, "R2 power-up delay", first_cs, PWRUP);
    check(flen[0] == 1 && fb[0][0] == 8'h11, "R5 stop frame", {flen[0], fb[0][0]}, {32'd1, 8'h11});
    check(flen[1] == NREG + 2, "R6 burst in one frame", flen[1], NREG + 2);
    check(fb[1][0] == 8'h40, "R6 write opcode", fb[1][0], 8'h40);
    check(fb[1][1] == 8'(NREG - 1), "R6 count byte", fb[1][1], NREG - 1);
    for (int k = 0; k < NREG; k++)
      check(fb[1][k+2] == cfg[8*k +: 8], "R6 register byte", fb[1][k+2], cfg[8*k +: 8]);
    check(flen[2] == 1 && fb[2][0] == 8'h10, "R7 start frame", {flen[2], fb[2][0]}, {32'd1, 8'h10});
    check(fstart[0] == 0 && fstart[1] == 0 && fstart[2] == 0, "R7 start low during config",
          {fstart[0], fstart[1], fstart[2]}, 0);
    repeat (200) @(negedge clk);
    check(nfr == 3, "R9 no read before start", nfr, 3);
    check(n_valid == 0, "R9 no result before start", n_valid, 0);
  endtask

  task automatic t_read(input logic [23:0] w);
    int f0 = nfr, v0 = n_valid, guard = 0;
    logic [23:0] got = '0;
    adc_word = w;
    drdy_n = 1'b0;
    while (n_valid == v0 && guard < 2000) begin
      @(negedge clk); guard++;
      if (valid) got = result;
      if (guard == 20) drdy_n = 1'b1;
    end
    drdy_n = 1'b1;
    @(negedge clk);
    check(valid == 1'b0, "R10 valid one cycle", valid, 0);
    check(got == w, "R10 result word", got, w);
    repeat (100) @(negedge clk);
    check(nfr == f0 + 1 && flen[f0] == 3 && fstart[f0] == 1, "R10 three-byte frame",
          flen[f0], 3);
  endtask

  task automatic t_overrun();
    int f0 = nfr, o0 = n_over, v0 = n_valid;
    adc_word = 24'h5A0F96;
    drdy_n = 1'b0;
    repeat (100) @(negedge clk);
    drdy_n = 1'b1;
    repeat (10) @(negedge clk);
    drdy_n = 1'b0;
    repeat (10) @(negedge clk);
    drdy_n = 1'b1;
    repeat (800) @(negedge clk);
    check(n_over == o0 + 1, "R11 overrun flagged", n_over - o0, 1);
    check(n_valid == v0 + 1 && result == 24'h5A0F96, "R11 current read kept", result, 24'h5A0F96);
    check(nfr == f0 + 1, "R11 dropped edge starts no frame", nfr - f0, 1);
  endtask

  task automatic t_timing();
    // full SCLK period in system cycles must cover 1.8 converter clocks
    check(longint'(min_per) * 10 * CONV_KHZ >= longint'(18) * SYS_KHZ, "R4 sclk period", min_per, 13);
    check(min_gap * CONV_KHZ * 10 >= GAP_SCLK * 18 * SYS_KHZ, "R8 cs gap", min_gap, GAP_SCLK * 13);
  endtask

  bit finished = 0;
  initial begin
    cfg = {8'h40, 8'h00, 8'h00, 8'h33, 8'h22, 8'h11, 8'h34, 8'h08, 8'h04};
    @(negedge clk);
    t_reset();
    t_bringup();
    t_read(24'hA5C317);
    t_read(24'h800001);
    t_read(24'hFFFFFF);
    t_read(24'h000000);
    t_overrun();
    t_read(24'h123456);
    t_timing();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule